// File: doc/BRIEF.md
# Free-Running Tick Counter with Compare-Match Interrupt

This peripheral keeps a wide free-running tick count that advances once for every cycle in which a tick-enable strobe from a slow reference (nominally 32768 Hz) is high. One compare channel watches the low word of that count. When the channel is armed and the low word equals the programmed compare value, a sticky match flag is raised, and a level interrupt follows it for as long as the channel stays armed.

Software reaches the block through a simple word-addressed register port with separate read and write strobes. The count is exposed as two read-only words with no latching between them. A consistent wide value is therefore obtained by reading the high word, then the low word, then the high word again, and retrying if the two high reads differ. Software is expected to place events between 6 and 2^DATA_W-1 ticks ahead of the current low word.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count is zero, the compare value is zero, the channel is disarmed, the match flag is clear and `irq` is low.
- R2: The count increments by exactly one on each clock where `tick_en` is high and holds otherwise; when the low word wraps from all ones to zero, the high word increments in the same clock.
- R3: Writes to word address 1 (count low) and word address 2 (count high) have no effect on the count.
- R4: Word address 0 reads the control/status word with the match flag at bit 0, the arm bit at bit 4 and zeros elsewhere; word address 1 reads the count low word, word address 2 the count high word, and word address 3 the compare value, which is read/write.
- R5: When the channel is armed and the count low word equals the compare value, the match flag reads 1 from the next clock.
- R6: Once set, the match flag stays set after the count moves past the compare value, and also while the channel is disarmed, until software clears it.
- R7: A write to word address 0 with bit 0 set clears the match flag; with bit 0 clear it leaves the flag unchanged; in both cases bit 4 of the same write becomes the new arm bit.
- R8: If a clear write and a new match fall in the same clock, the flag remains set.
- R9: `irq` is high exactly when the match flag is set and the channel is armed.
- R10: `rdata` is zero in any clock where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock strobe from the slow reference; advances the count |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address (0 control/status, 1 count low, 2 count high, 3 compare) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the same clock as `rd_en` |
| irq | output | 1 | Level interrupt: match flag AND arm bit |

## Verification
The embedded properties assume `rd_en` and `wr_en` are treated independently and that `tick_en` is a plain one-clock strobe with no relation to the register port, so any combination of tick, write and match in a single clock is legal and must be covered. The stimulus therefore mixes directed sequences, including a clear written while the count is parked on the compare value and a low-word wrap seen between two high-word reads, with a long run of random ticks, compare writes placed a few ticks ahead of the count and arm/clear writes. The bench instantiates the block with a narrow word and count so that a low-word wrap is reached in a few hundred ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CLO  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CHI  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CMP  = 2'd3;
  localparam int FLAG_BIT = 0;
  localparam int ARM_BIT  = 4;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  output logic [DATA_W-1:0] cnt_lo,
  output logic [CNT_W-DATA_W-1:0] cnt_hi
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic              lo_wrap;

  always_comb begin
    lo_wrap = &lo_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    if (tick_en) begin
      lo_d = lo_q + 1'b1;
      if (lo_wrap) hi_d = hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (tick_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_lo = lo_q;
  assign cnt_hi = hi_q;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> {cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 1'b1);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable({cnt_hi, cnt_lo}));
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cnt_lo,
  input  logic              cmp_wr,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmp_val,
  output logic              arm,
  output logic              flag
);
  import tmr_pkg::*;

  logic [DATA_W-1:0] cmp_q, cmp_d;
  logic arm_q, arm_d, flag_q, flag_d;
  logic hit, clr;

  always_comb begin
    hit    = arm_q && (cnt_lo == cmp_q);
    clr    = ctrl_wr && wdata[FLAG_BIT];
    cmp_d  = cmp_wr  ? wdata : cmp_q;
    arm_d  = ctrl_wr ? wdata[ARM_BIT] : arm_q;
    flag_d = hit | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cmp_wr)  cmp_q <= cmp_d;
      if (ctrl_wr) arm_q <= arm_d;
      flag_q <= flag_d;
    end
  end

  assign cmp_val = cmp_q;
  assign arm     = arm_q;
  assign flag    = flag_q;

  // R5
  match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && cnt_lo == cmp_val) |=> flag);
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(ctrl_wr && wdata[FLAG_BIT])) |=> flag);
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[FLAG_BIT] && !(arm && cnt_lo == cmp_val)) |=> !flag);
  // R8
  match_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[FLAG_BIT] && arm && cnt_lo == cmp_val) |=> flag);
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import tmr_pkg::*;
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] cnt_lo, cmp_val, ctrl_word, rd_mux;
  logic [HI_W-1:0]   cnt_hi;
  logic              arm, flag, ctrl_wr, cmp_wr;

  tmr_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
  );

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign cmp_wr  = wr_en && (addr == A_CMP);

  tmr_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt_lo(cnt_lo),
    .cmp_wr(cmp_wr), .ctrl_wr(ctrl_wr), .wdata(wdata),
    .cmp_val(cmp_val), .arm(arm), .flag(flag)
  );

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[FLAG_BIT] = flag;
    ctrl_word[ARM_BIT]  = arm;
    unique case (addr)
      A_CTRL:  rd_mux = ctrl_word;
      A_CLO:   rd_mux = cnt_lo;
      A_CHI:   rd_mux = DATA_W'(cnt_hi);
      default: rd_mux = cmp_val;
    endcase
    rdata = rd_en ? rd_mux : '0;
  end

  assign irq = flag & arm;

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[ARM_BIT]) |=> !irq);
  // R10
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

// File: tb/tick_cmp_timer_test.sv
module tick_cmp_timer_test;
  localparam int DW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n, tick_en, wr_en, rd_en, irq;
  logic [1:0] addr;
  logic [DW-1:0] wdata, rdata;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int unsigned m_cnt, m_cmp;
  bit m_arm, m_flag;

  always #4 clk = ~clk;

  tick_cmp_timer #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, actual, expected, $time);
    end
  endtask

  function automatic int model_read(logic [1:0] a);
    case (a)
      2'd0: return (int'(m_arm) << 4) | int'(m_flag);
      2'd1: return m_cnt % 256;
      2'd2: return m_cnt / 256;
      default: return m_cmp;
    endcase
  endfunction

  // one clock: drive at negedge, compare, then advance the model at posedge
  task automatic step(bit tk, bit wr, bit rd, logic [1:0] a, int wd, string req);
    bit hit, clr;
    @(negedge clk);
    tick_en = tk; wr_en = wr; rd_en = rd; addr = a; wdata = DW'(wd);
    #1;
    check("R9", int'(irq), int'(m_flag && m_arm));
    if (rd) check(req, int'(rdata), model_read(a));
    else    check("R10", int'(rdata), 0);
    hit = m_arm && ((m_cnt % 256) == m_cmp);
    clr = wr && a == 2'd0 && wd[0];
    @(posedge clk);
    m_flag = hit || (m_flag && !clr);
    if (wr && a == 2'd0) m_arm = wd[4];
    if (wr && a == 2'd3) m_cmp = wd % 256;
    if (tk) m_cnt = (m_cnt + 1) % 65536;
  endtask

  task automatic idle(int n, bit tk);
    for (int i = 0; i < n; i++) step(tk, 0, 0, 2'd0, 0, "R2");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi1, hi2;
    rst_n = 1'b0; tick_en = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    m_cnt = 0; m_cmp = 0; m_arm = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state through every word
    for (int a = 0; a < 4; a++) step(0, 0, 1, 2'(a), 0, "R1");
    check("R1", int'(irq), 0);

    // R2: counting and holding
    idle(10, 1);
    idle(5, 0);
    step(0, 0, 1, 2'd1, 0, "R2");
    check("R2", int'(rdata), 10);

    // R3: writes to count words ignored
    step(1, 1, 0, 2'd1, 8'hAA, "R3");
    step(0, 1, 0, 2'd2, 8'h55, "R3");
    step(0, 0, 1, 2'd1, 0, "R3");
    step(0, 0, 1, 2'd2, 0, "R3");

    // R4: compare read/write, arm
    step(0, 1, 0, 2'd3, 20, "R4");
    step(0, 0, 1, 2'd3, 0, "R4");
    step(0, 1, 0, 2'd0, 8'h10, "R4");
    step(0, 0, 1, 2'd0, 0, "R4");

    // R5/R6: match then sticky while count moves on
    idle(15, 1);
    step(0, 0, 1, 2'd0, 0, "R5");
    check("R5", int'(irq), 1);
    idle(5, 1);
    step(0, 0, 1, 2'd0, 0, "R6");

    // R9/R6: disarm masks irq, flag stays
    step(0, 1, 0, 2'd0, 8'h00, "R9");
    step(0, 0, 1, 2'd0, 0, "R6");
    check("R9", int'(irq), 0);

    // R7: write 0 to bit 0 keeps flag, write 1 clears and rearms
    step(0, 1, 0, 2'd0, 8'h10, "R7");
    step(0, 0, 1, 2'd0, 0, "R7");
    step(0, 1, 0, 2'd0, 8'h11, "R7");
    step(0, 0, 1, 2'd0, 0, "R7");

    // R8: park count on compare value, clear in same clock as match
    step(0, 0, 1, 2'd1, 0, "R8");
    step(0, 1, 0, 2'd3, model_read(2'd1), "R8");
    step(0, 0, 0, 2'd0, 0, "R8");
    step(0, 1, 0, 2'd0, 8'h11, "R8");
    step(0, 0, 1, 2'd0, 0, "R8");
    step(0, 1, 0, 2'd0, 8'h01, "R8");

    // R2: low-word wrap visible between two high reads
    step(0, 0, 1, 2'd2, 0, "R2");
    hi1 = int'(rdata);
    idle(300, 1);
    step(0, 0, 1, 2'd1, 0, "R2");
    step(0, 0, 1, 2'd2, 0, "R2");
    hi2 = int'(rdata);
    check("R2", int'(hi2 != hi1), 1);

    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r, a, d;
      r = $urandom % 16;
      a = $urandom % 4;
      d = $urandom % 256;
      if (r == 0)      step($urandom % 2, 1, 1, 2'd3, (model_read(2'd1) + 6 + $urandom % 10) % 256, "R4");
      else if (r == 1) step($urandom % 2, 1, 1, 2'd0, d, "R7");
      else if (r == 2) step($urandom % 2, 1, 1, 2'(a), d, "R3");
      else             step($urandom % 2, 0, $urandom % 2, 2'(a), 0, "R5");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule